// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block interprets host write cycles aimed at a byte-wide flash array model and recognises the six-write sector erase command. After the first sector has been named, it holds an acceptance window open. During that window the host can name further sectors, each of which sets a bit in a per-sector selection vector and starts the window again. When the window runs out, the block starts an erase engine on the selected sectors. That engine can be suspended and later resumed. The physical erase is modelled as a busy period of fixed length.

The same command stream also carries a small program command, which produces a single-cycle array write strobe followed by a short busy period. While an erase is suspended, the host may program any sector that is not selected for erase. Reads that land in a selected sector while an erase operation is in progress return a status byte in place of array data. A ready flag and a window-closed flag report progress. All time windows are whole clock-cycle counts, derived from a clock-frequency parameter given in MHz.

Top module: `flashEraseSeq`

## Requirements
- R1: After reset, ready and windowClosed are 1, eraseActive and suspended are 0, eraseSel is all zero, and no array write strobe is issued.
- R2: The writes AA at low address 0x555, 55 at 0x2AA, 80 at 0x555, AA at 0x555, 55 at 0x2AA, then 30 at any address open the acceptance window (the low address is bits 11:0). In the cycle after the sixth write, the eraseSel bit indexed by the top SECT_W address bits of that write is set, ready is 0 and windowClosed is 0.
- R3: While the window is open, a write of 30 sets the eraseSel bit of its sector and restarts the window. A write of 30 in the window's final cycle is still accepted. After CLK_MHZ*WINDOW_US cycles with no such write, the erase starts: eraseActive goes to 1 and windowClosed goes to 1.
- R4: While the window is open, any write other than 30 or B0 clears eraseSel and returns to read mode, with ready at 1.
- R5: A write that breaks the unlock/setup sequence, or a write of F0, returns the decoder to its first step without opening a window or issuing a program.
- R6: While the erase is active, every write except B0 is ignored: eraseActive and eraseSel stay unchanged.
- R7: A B0 write while the window is open enters the suspended state in the next cycle, with suspended at 1, ready at 1 and windowClosed at 1.
- R8: A B0 write during an active erase drops eraseActive. ready stays 0 for CLK_MHZ*SUSP_US cycles and suspended then rises. No erase progress is made while waiting.
- R9: An erase completes after ERASE_CYCLES cycles of eraseActive in total, counted across any suspensions. It then clears eraseSel and sets ready. While suspended, a write of 30 at any address resumes the erase.
- R10: rdStatusSel is 1 when the sector of rdAddr is selected and any erase phase (window, active, pending suspend or suspended) is in progress. The status byte is: bit 7 set when suspended, bit 6 toggling on each status read unless suspended, bit 3 equal to windowClosed, bit 2 toggling on each status read, and all other bits 0.
- R11: The writes AA at 0x555, 55 at 0x2AA, A0 at 0x555, then a data write produce one arrayWrEn pulse in the next cycle, carrying that write's address and data. ready is then 0 for PROG_CYCLES cycles, and writes (including B0) are ignored during that time. While suspended, a program to a selected sector is dropped.
- R12: Asserting rstN low during any operation returns every output to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write cycle, one clock per write |
| wrAddr | input | ADDR_W | Host write address |
| wrData | input | 8 | Host write data / command byte |
| rdEn | input | 1 | Host read cycle |
| rdAddr | input | ADDR_W | Host read address |
| ready | output | 1 | 1 when idle or suspended and no program busy |
| windowClosed | output | 1 | 0 only while the acceptance window is open |
| eraseActive | output | 1 | Erase engine running |
| suspended | output | 1 | Erase suspended |
| eraseSel | output | 2**SECT_W | One bit per sector selected for erase |
| rdStatusSel | output | 1 | Read returns status instead of array data |
| rdStatus | output | 8 | Status byte |
| arrayWrEn | output | 1 | Single-cycle array program strobe |
| arrayWrAddr | output | ADDR_W | Array program address |
| arrayWrData | output | 8 | Array program data |

## Verification
The bench builds the block with CLK_MHZ=1, ADDR_W=16, SECT_W=4, ERASE_CYCLES=60 and PROG_CYCLES=4. These values give a 50-cycle acceptance window, a 20-cycle suspend latency and sixteen 4 KB sectors. With them, the last-cycle window restart, the expiry instant, the suspend wait and the remaining-erase count after a resume can each be reached in a few dozen cycles and checked at exact cycle offsets. A behavioural model of sector sets, countdowns and toggle bits runs alongside the block and is compared on every clock, including across a mid-erase reset.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_WINDOW,
    OP_ERASE,
    OP_SPEND,
    OP_SUSP
  } opState_e;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_SETUP,
    ST_UNL3,
    ST_UNL4,
    ST_PDATA
  } cmdStep_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic selClear;
    logic selAdd;
    logic winRestart;
    logic windowOpen;
    logic eraseLoad;
    logic eraseRun;
    logic suspLoad;
    logic suspRun;
    logic progLoad;
    logic statusEn;
    logic suspFlag;
  } seqStrobes_t;

  localparam logic [7:0]  CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0]  CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0]  CMD_SETUP    = 8'h80;
  localparam logic [7:0]  CMD_ERASE_GO = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0]  CMD_PROGRAM  = 8'hA0;
  localparam logic [11:0] ADDR_KEY_A   = 12'h555;
  localparam logic [11:0] ADDR_KEY_B   = 12'h2AA;

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              winDone,
  input  logic              eraseLast,
  input  logic              suspLast,
  input  logic              progBusy,
  input  logic              wrHitSel,
  output seqStrobes_t       str,
  output logic              ready,
  output logic              windowClosed,
  output logic              eraseActive,
  output logic              suspended
);

  opState_e opState, nextOp;
  cmdStep_e cmdStep, nextStep;

  logic atKeyA, atKeyB, unlockA, unlockB;

  assign atKeyA  = (wrAddr[11:0] == ADDR_KEY_A);
  assign atKeyB  = (wrAddr[11:0] == ADDR_KEY_B);
  assign unlockA = atKeyA && (wrData == CMD_UNLOCK_A);
  assign unlockB = atKeyB && (wrData == CMD_UNLOCK_B);

  always_comb begin
    str            = '0;
    nextOp         = opState;
    nextStep       = cmdStep;
    str.statusEn   = (opState != OP_IDLE);
    str.suspFlag   = (opState == OP_SUSP);
    str.windowOpen = (opState == OP_WINDOW);
    str.suspRun    = (opState == OP_SPEND);
    case (opState)
      OP_WINDOW: begin
        if (wrEn) begin
          if (wrData == CMD_ERASE_GO) begin
            str.selAdd     = 1'b1;
            str.winRestart = 1'b1;
          end else if (wrData == CMD_SUSPEND) begin
            nextOp        = OP_SUSP;
            str.eraseLoad = 1'b1;
          end else begin
            nextOp       = OP_IDLE;
            str.selClear = 1'b1;
          end
        end else if (winDone) begin
          nextOp        = OP_ERASE;
          str.eraseLoad = 1'b1;
        end
      end
      OP_ERASE: begin
        if (wrEn && (wrData == CMD_SUSPEND)) begin
          nextOp       = OP_SPEND;
          str.suspLoad = 1'b1;
        end else begin
          str.eraseRun = 1'b1;
          if (eraseLast) begin
            nextOp       = OP_IDLE;
            str.selClear = 1'b1;
          end
        end
      end
      OP_SPEND: begin
        if (suspLast) nextOp = OP_SUSP;
      end
      default: begin
        if (wrEn && !progBusy) begin
          nextStep = ST_READ;
          case (cmdStep)
            ST_READ: begin
              if (unlockA) nextStep = ST_UNL1;
              else if ((opState == OP_SUSP) && (wrData == CMD_ERASE_GO)) nextOp = OP_ERASE;
            end
            ST_UNL1: if (unlockB) nextStep = ST_UNL2;
            ST_UNL2: begin
              if (atKeyA && (wrData == CMD_SETUP) && (opState == OP_IDLE)) nextStep = ST_SETUP;
              else if (atKeyA && (wrData == CMD_PROGRAM)) nextStep = ST_PDATA;
            end
            ST_SETUP: if (unlockA) nextStep = ST_UNL3;
            ST_UNL3:  if (unlockB) nextStep = ST_UNL4;
            ST_UNL4: begin
              if (wrData == CMD_ERASE_GO) begin
                nextOp         = OP_WINDOW;
                str.selAdd     = 1'b1;
                str.winRestart = 1'b1;
              end
            end
            ST_PDATA: begin
              if ((opState == OP_IDLE) || !wrHitSel) str.progLoad = 1'b1;
            end
            default: nextStep = ST_READ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState <= OP_IDLE;
      cmdStep <= ST_READ;
    end else begin
      opState <= nextOp;
      cmdStep <= nextStep;
    end
  end

  always_comb begin
    ready        = !((opState == OP_WINDOW) || (opState == OP_ERASE) || (opState == OP_SPEND)) && !progBusy;
    windowClosed = (opState != OP_WINDOW);
    eraseActive  = (opState == OP_ERASE);
    suspended    = (opState == OP_SUSP);
  end

  // R7: suspend during the window takes effect in the next cycle
  a_r7_window_suspend_now: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_WINDOW && wrEn && wrData == CMD_SUSPEND) |=> (suspended && ready));

  // R6: erase ignores every write except suspend
  a_r6_erase_ignores_writes: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_ERASE && wrEn && wrData != CMD_SUSPEND && !eraseLast) |=> eraseActive);

  // R8: suspend pending keeps the block busy
  a_r8_pending_is_busy: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_SPEND) |-> !ready);

  // R4: a foreign command inside the window aborts to read mode
  a_r4_window_abort: assert property (@(posedge clk) disable iff (!rstN)
    (opState == OP_WINDOW && wrEn && wrData != CMD_ERASE_GO && wrData != CMD_SUSPEND)
      |=> (ready && windowClosed && !suspended));

endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECT_W       = 4,
  parameter int WIN_CYC      = 2500,
  parameter int SUSP_CYC     = 1000,
  parameter int ERASE_CYCLES = 100000,
  parameter int PROG_CYCLES  = 350
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobes_t            str,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic                   winDone,
  output logic                   eraseLast,
  output logic                   suspLast,
  output logic                   progBusy,
  output logic                   wrHitSel,
  output logic [(1<<SECT_W)-1:0] eraseSel,
  output logic                   rdStatusSel,
  output logic [7:0]             rdStatus,
  output logic                   arrayWrEn,
  output logic [ADDR_W-1:0]      arrayWrAddr,
  output logic [7:0]             arrayWrData
);

  localparam int NSECT  = 1 << SECT_W;
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int SUSP_W = $clog2(SUSP_CYC + 1);
  localparam int ER_W   = $clog2(ERASE_CYCLES + 1);
  localparam int PR_W   = $clog2(PROG_CYCLES + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);
  localparam logic [SUSP_W-1:0] SUSP_INIT = SUSP_W'(SUSP_CYC);
  localparam logic [ER_W-1:0]   ER_INIT   = ER_W'(ERASE_CYCLES);
  localparam logic [PR_W-1:0]   PR_INIT   = PR_W'(PROG_CYCLES);

  logic [SECT_W-1:0] wrSector, rdSector;
  logic [WIN_W-1:0]  winCnt;
  logic [SUSP_W-1:0] suspCnt;
  logic [ER_W-1:0]   eraseCnt;
  logic [PR_W-1:0]   progCnt;
  logic              tog2, tog6;

  assign wrSector = wrAddr[ADDR_W-1 -: SECT_W];
  assign rdSector = rdAddr[ADDR_W-1 -: SECT_W];

  // one selection flop per sector
  for (genvar s = 0; s < NSECT; s++) begin : gSel
    logic selQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                              selQ <= 1'b0;
      else if (str.selClear)                                  selQ <= 1'b0;
      else if (str.selAdd && (wrSector == SECT_W'(s)))        selQ <= 1'b1;
    end
    assign eraseSel[s] = selQ;
  end

  assign wrHitSel    = eraseSel[wrSector];
  assign rdStatusSel = str.statusEn && eraseSel[rdSector];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               winCnt <= '0;
    else if (str.winRestart) winCnt <= '0;
    else if (str.windowOpen) winCnt <= winCnt + 1'b1;
  end
  assign winDone = str.windowOpen && (winCnt == WIN_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              eraseCnt <= '0;
    else if (str.eraseLoad) eraseCnt <= ER_INIT;
    else if (str.eraseRun)  eraseCnt <= eraseCnt - 1'b1;
  end
  assign eraseLast = (eraseCnt == ER_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             suspCnt <= '0;
    else if (str.suspLoad) suspCnt <= SUSP_INIT;
    else if (str.suspRun)  suspCnt <= suspCnt - 1'b1;
  end
  assign suspLast = (suspCnt == SUSP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             progCnt <= '0;
    else if (str.progLoad) progCnt <= PR_INIT;
    else if (progCnt != '0) progCnt <= progCnt - 1'b1;
  end
  assign progBusy = (progCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrayWrEn   <= 1'b0;
      arrayWrAddr <= '0;
      arrayWrData <= '0;
    end else begin
      arrayWrEn <= str.progLoad;
      if (str.progLoad) begin
        arrayWrAddr <= wrAddr;
        arrayWrData <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog2 <= 1'b0;
      tog6 <= 1'b0;
    end else if (rdEn && rdStatusSel) begin
      tog2 <= ~tog2;
      if (!str.suspFlag) tog6 <= ~tog6;
    end
  end

  assign rdStatus = {str.suspFlag, tog6, 2'b00, !str.windowOpen, tog2, 2'b00};

  // R3: an added sector is visible in the selection next cycle
  a_r3_add_sets_bit: assert property (@(posedge clk) disable iff (!rstN)
    str.selAdd |=> eraseSel[$past(wrSector)]);

  // R11: program strobe lasts a single cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |=> !arrayWrEn);

  // R8: erase progress frozen outside active erase
  a_r8_erase_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!str.eraseRun && !str.eraseLoad) |=> $stable(eraseCnt));

  // R10: status only returned for a non-empty selection
  a_r10_status_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    rdStatusSel |-> (eraseSel != '0));

endmodule

// File: rtl/flashEraseSeq.sv
module flashEraseSeq
  import flashSeqPkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECT_W       = 4,
  parameter int CLK_MHZ      = 50,
  parameter int WINDOW_US    = 50,
  parameter int SUSP_US      = 20,
  parameter int ERASE_CYCLES = 100000,
  parameter int PROG_CYCLES  = 350
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic                   ready,
  output logic                   windowClosed,
  output logic                   eraseActive,
  output logic                   suspended,
  output logic [(1<<SECT_W)-1:0] eraseSel,
  output logic                   rdStatusSel,
  output logic [7:0]             rdStatus,
  output logic                   arrayWrEn,
  output logic [ADDR_W-1:0]      arrayWrAddr,
  output logic [7:0]             arrayWrData
);

  localparam int WIN_CYC  = CLK_MHZ * WINDOW_US;
  localparam int SUSP_CYC = CLK_MHZ * SUSP_US;

  seqStrobes_t str;
  logic winDone, eraseLast, suspLast, progBusy, wrHitSel;

  flashSeqCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .winDone(winDone), .eraseLast(eraseLast), .suspLast(suspLast),
    .progBusy(progBusy), .wrHitSel(wrHitSel), .str(str),
    .ready(ready), .windowClosed(windowClosed),
    .eraseActive(eraseActive), .suspended(suspended)
  );

  flashSeqData #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYC(WIN_CYC), .SUSP_CYC(SUSP_CYC),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) i_data (
    .clk(clk), .rstN(rstN), .str(str), .rdEn(rdEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .winDone(winDone), .eraseLast(eraseLast), .suspLast(suspLast),
    .progBusy(progBusy), .wrHitSel(wrHitSel), .eraseSel(eraseSel),
    .rdStatusSel(rdStatusSel), .rdStatus(rdStatus),
    .arrayWrEn(arrayWrEn), .arrayWrAddr(arrayWrAddr), .arrayWrData(arrayWrData)
  );

endmodule

// File: tb/test_flashEraseSeq.sv
module test_flashEraseSeq;

  localparam int ADDR_W = 16;
  localparam int SECT_W = 4;
  localparam int WIN    = 50;
  localparam int SUSP   = 20;
  localparam int ERASE  = 60;
  localparam int PROG   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic rdEn = 1'b0;
  logic [15:0] rdAddr = '0;
  logic ready, windowClosed, eraseActive, suspended, rdStatusSel, arrayWrEn;
  logic [15:0] eraseSel, arrayWrAddr;
  logic [7:0]  rdStatus, arrayWrData;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit cmpOn = 0;

  always #10 clk = ~clk;

  flashEraseSeq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .CLK_MHZ(1), .WINDOW_US(50), .SUSP_US(20),
    .ERASE_CYCLES(ERASE), .PROG_CYCLES(PROG)
  ) i_flashEraseSeq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .ready(ready), .windowClosed(windowClosed),
    .eraseActive(eraseActive), .suspended(suspended), .eraseSel(eraseSel),
    .rdStatusSel(rdStatusSel), .rdStatus(rdStatus), .arrayWrEn(arrayWrEn),
    .arrayWrAddr(arrayWrAddr), .arrayWrData(arrayWrData)
  );

  // behavioural model: mode 0 read, 1 window, 2 erasing, 3 suspend pending, 4 suspended
  int mMode = 0, mStep = 0, mWin = 0, mErase = 0, mSusp = 0, mProg = 0;
  bit [15:0] mSel = '0;
  bit mTog2 = 0, mTog6 = 0, mArrEn = 0;
  bit [15:0] mArrAddr = '0;
  bit [7:0]  mArrData = '0;

  function automatic bit keyA(); return wrAddr[11:0] == 12'h555; endfunction

  task automatic modelDecode(bit hit);
    int s = mStep;
    mStep = 0;
    if (s == 0) begin
      if (keyA() && wrData == 8'hAA) mStep = 1;
      else if (mMode == 4 && wrData == 8'h30) mMode = 2;
    end else if (s == 1 || s == 4) begin
      if (wrAddr[11:0] == 12'h2AA && wrData == 8'h55) mStep = s + 1;
    end else if (s == 2) begin
      if (keyA() && wrData == 8'h80 && mMode == 0) mStep = 3;
      else if (keyA() && wrData == 8'hA0) mStep = 6;
    end else if (s == 3) begin
      if (keyA() && wrData == 8'hAA) mStep = 4;
    end else if (s == 5) begin
      if (wrData == 8'h30) begin
        mMode = 1; mWin = WIN; mSel[wrAddr[15:12]] = 1'b1;
      end
    end else if (s == 6) begin
      if (mMode == 0 || !hit) begin
        mProg = PROG; mArrEn = 1; mArrAddr = wrAddr; mArrData = wrData;
      end
    end
  endtask

  task automatic modelStep();
    bit busy = (mProg != 0);
    bit hit = mSel[wrAddr[15:12]];
    mArrEn = 0;
    if (mProg != 0) mProg--;
    if (rdEn && mMode != 0 && mSel[rdAddr[15:12]]) begin
      mTog2 = ~mTog2;
      if (mMode != 4) mTog6 = ~mTog6;
    end
    case (mMode)
      1: begin
        if (wrEn) begin
          if (wrData == 8'h30) begin mSel[wrAddr[15:12]] = 1'b1; mWin = WIN; end
          else if (wrData == 8'hB0) begin mMode = 4; mErase = ERASE; end
          else begin mMode = 0; mSel = '0; end
        end else begin
          mWin--;
          if (mWin == 0) begin mMode = 2; mErase = ERASE; end
        end
      end
      2: begin
        if (wrEn && wrData == 8'hB0) begin mMode = 3; mSusp = SUSP; end
        else begin
          mErase--;
          if (mErase == 0) begin mMode = 0; mSel = '0; end
        end
      end
      3: begin
        mSusp--;
        if (mSusp == 0) mMode = 4;
      end
      default: if (wrEn && !busy) modelDecode(hit);
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mStep = 0; mWin = 0; mErase = 0; mSusp = 0; mProg = 0;
      mSel = '0; mTog2 = 0; mTog6 = 0; mArrEn = 0; mArrAddr = '0; mArrData = '0;
    end else modelStep();
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic checkModel();
    bit busyMode = (mMode == 1 || mMode == 2 || mMode == 3);
    bit sSel = (mMode != 0) && mSel[rdAddr[15:12]];
    cmp("R8",  "ready",        ready,        !busyMode && mProg == 0);
    cmp("R3",  "windowClosed", windowClosed, mMode != 1);
    cmp("R6",  "eraseActive",  eraseActive,  mMode == 2);
    cmp("R7",  "suspended",    suspended,    mMode == 4);
    cmp("R2",  "eraseSel",     eraseSel,     mSel);
    cmp("R11", "arrayWrEn",    arrayWrEn,    mArrEn);
    if (mArrEn) begin
      cmp("R11", "arrayWrAddr", arrayWrAddr, mArrAddr);
      cmp("R11", "arrayWrData", arrayWrData, mArrData);
    end
    cmp("R10", "rdStatusSel",  rdStatusSel,  sSel);
    cmp("R10", "rdStatus",     rdStatus,
        {24'd0, mMode == 4, mTog6, 2'b00, mMode != 1, mTog2, 2'b00});
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cmpOn) checkModel();
  endtask

  task automatic idle(int n);
    wrEn = 0; rdEn = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    step();
    wrEn = 0;
  endtask

  task automatic rd(logic [15:0] a);
    rdEn = 1; rdAddr = a;
    #1;
    checkModel();
    step();
    rdEn = 0;
  endtask

  task automatic eraseCmd(logic [15:0] a);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(a, 8'h30);
  endtask

  task automatic progCmd(logic [15:0] a, logic [7:0] d);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0); wr(a, d);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=%0d expected<20000", cycles);
      summary();
    end
  end

  initial begin
    idle(1);
    cmpOn = 1;
    idle(2);
    rstN = 1;
    idle(1);
    // R1: reset state
    cmp("R1", "ready", ready, 1);
    cmp("R1", "windowClosed", windowClosed, 1);
    cmp("R1", "eraseSel", eraseSel, 0);

    // R2, R3, R6, R9, R10: single sector erase, exact timing
    eraseCmd(16'h3000);
    cmp("R2", "sel after sequence", eraseSel, 16'h0008);
    cmp("R2", "ready in window", ready, 0);
    idle(49);
    cmp("R3", "still window", windowClosed, 0);
    idle(1);
    cmp("R3", "erase begins", eraseActive, 1);
    rd(16'h3010);
    cmp("R10", "status sel", rdStatusSel, 1);
    wr(16'h0555, 8'hF0);
    cmp("R6", "ignored write", eraseActive, 1);
    idle(57);
    cmp("R9", "erase running", eraseActive, 1);
    idle(1);
    cmp("R9", "erase done", ready, 1);
    cmp("R9", "sel cleared", eraseSel, 0);

    // R3: restart in last cycle, multiple sectors; R8, R10, R11, R9 on suspend/resume
    eraseCmd(16'h1000);
    idle(49);
    wr(16'h5000, 8'h30);
    cmp("R3", "last-cycle add", eraseSel, 16'h0022);
    idle(49);
    wr(16'h0000, 8'h30);
    idle(50);
    cmp("R3", "erase after restarts", eraseActive, 1);
    idle(10);
    wr(16'h7777, 8'hB0);
    idle(19);
    cmp("R8", "pending not suspended", suspended, 0);
    cmp("R8", "pending busy", ready, 0);
    idle(1);
    cmp("R8", "suspended", suspended, 1);
    rd(16'h1004);
    cmp("R10", "suspended status", rdStatus[7], 1);
    rd(16'h2004);
    cmp("R10", "unselected read", rdStatusSel, 0);
    progCmd(16'h5010, 8'h11);
    cmp("R11", "selected program dropped", arrayWrEn, 0);
    progCmd(16'h2010, 8'h5A);
    cmp("R11", "program strobe", arrayWrEn, 1);
    cmp("R11", "program addr", arrayWrAddr, 16'h2010);
    idle(4);
    cmp("R11", "ready after program", ready, 1);
    wr(16'h0000, 8'h30);
    cmp("R9", "resumed", eraseActive, 1);
    idle(49);
    cmp("R9", "remaining count", eraseActive, 1);
    idle(1);
    cmp("R9", "done after resume", ready, 1);

    // R4: abort inside window
    eraseCmd(16'h7000);
    wr(16'h0555, 8'h80);
    cmp("R4", "abort ready", ready, 1);
    cmp("R4", "abort sel", eraseSel, 0);

    // R5: broken unlock
    wr(16'h0555, 8'hAA); wr(16'h0123, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h4000, 8'h30);
    cmp("R5", "no window", windowClosed, 1);
    cmp("R5", "no sel", eraseSel, 0);

    // R11: program from read, suspend during program ignored
    progCmd(16'h6020, 8'hC3);
    cmp("R11", "pulse", arrayWrEn, 1);
    wr(16'h0000, 8'hB0);
    cmp("R11", "suspend ignored", suspended, 0);
    idle(4);

    // R7: suspend in window, toggles, R12 reset mid erase
    eraseCmd(16'h9000);
    wr(16'h0000, 8'hB0);
    cmp("R7", "window suspend", suspended, 1);
    cmp("R7", "ready", ready, 1);
    wr(16'h0000, 8'h30);
    rd(16'h9000);
    rd(16'h9000);
    idle(5);
    rstN = 0;
    idle(1);
    cmp("R12", "reset eraseActive", eraseActive, 0);
    cmp("R12", "reset sel", eraseSel, 0);
    rstN = 1;
    idle(2);
    summary();
  end

endmodule